// File: doc/BRIEF.md
# Card Host Byte FIFO Data Path

This block moves payload bytes between a host register port and a card-side byte stream. It has two 32-byte queues. A transmit queue takes 1-, 2- or 4-byte host writes and unpacks each one into bytes. Those bytes go to the card one at a time. A receive queue collects bytes from the card and packs them into host words of the width each read asks for. In both directions the most significant used byte lane is handled first.

A transfer begins with a start pulse. The pulse loads a byte count, latches the direction and empties both queues. While the transfer is active and the count is nonzero, bytes cross the card interface through a valid/ready handshake, at most one byte per clock. When the count reaches zero the transfer ends. It raises a data-done flag, and in the write direction it also raises a program-done flag. A flush command throws away any bytes still waiting in the transmit queue. The block also drives service requests for each queue.

Top module: `card_fifo_datapath`

## Requirements
- R1: Each queue holds at most 32 bytes. `tx_level` and `rx_level` report the occupancy. A host write that needs more room than is free stores only as many bytes as fit and drops the rest.
- R2: `host_wr_size` selects the write width: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. For a write of N bytes, byte lane N-1 (bits 8N-1:8N-8) is queued first and lane 0 last.
- R3: `host_rd_size` uses the same encoding. A read of N bytes removes min(N, rx_level) bytes. The oldest byte appears in lane N-1 and later bytes in lower lanes. Lanes not filled, and all lanes above N-1, read as zero.
- R4: `card_tx_valid` is high when the transfer is active, the direction is write, the remaining count is nonzero and the transmit queue is not empty. `card_tx_data` is then the oldest queued byte. It is removed on a cycle with `card_tx_valid` and `card_tx_ready` both high.
- R5: `card_rx_ready` is high when the transfer is active, the direction is read, the remaining count is nonzero and `rx_level` is below 32. `card_rx_data` is stored on a cycle with `card_rx_valid` and `card_rx_ready` both high.
- R6: A start loads the remaining count from `xfer_len` and sets `xfer_active`. Each byte crossing the card interface lowers the count by one. On the edge where the count reaches zero, `xfer_active` falls and `data_done` rises. `prog_done` also rises when the direction is write. A length of 0 completes on the first edge after the start.
- R7: `tx_req` is high exactly while a write-direction transfer is active. `rx_req` is set by each received card byte. It is cleared by a host read in a cycle with no arrival, and by a start.
- R8: A `flush` pulse (without a start) empties the transmit queue, including any host write in the same cycle. The receive queue is unaffected.
- R9: A start empties both queues, discards host accesses in the same cycle, and clears `data_done`, `prog_done` and `rx_req`. While no transfer is active, no byte crosses the card interface.
- R10: After reset both queues are empty, no transfer is active and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new transfer |
| dir_write | input | 1 | Direction latched at start: 1 host-to-card, 0 card-to-host |
| xfer_len | input | 16 | Byte count latched at start |
| flush | input | 1 | Discard queued transmit bytes |
| host_wr_en | input | 1 | Host write to transmit queue |
| host_wr_size | input | 2 | Width code of the host write |
| host_wr_data | input | 32 | Host write word |
| host_rd_en | input | 1 | Host read from receive queue |
| host_rd_size | input | 2 | Width code of the host read |
| host_rd_data | output | 32 | Packed read word, valid in a read cycle |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_ready | input | 1 | Card accepts the offered byte |
| card_tx_data | output | 8 | Byte to the card |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_ready | output | 1 | Block can accept a card byte |
| card_rx_data | input | 8 | Byte from the card |
| xfer_active | output | 1 | Transfer in progress |
| tx_req | output | 1 | Transmit queue needs service |
| rx_req | output | 1 | Receive queue has new data |
| data_done | output | 1 | Sticky: transfer completed |
| prog_done | output | 1 | Sticky: write transfer completed |
| tx_level | output | 6 | Transmit queue occupancy |
| rx_level | output | 6 | Receive queue occupancy |

## Verification
The assertions check four things on every cycle: the occupancy bound, that the card interface stays silent while idle, that a full receive queue refuses bytes, and the effects of start, flush and completion on the next edge. Other behaviour depends on sequences of operations, and only the bench's scenarios can show it. This covers byte ordering through pack and unpack, partial reads padded with zeros, dropping of bytes past a full queue, and the exact edge on which the count runs out. A queue-based reference model in the bench follows every host access and handshake to check these.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;
  localparam int unsigned HOST_BYTES = 4;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORD2 = 2'd3
  } acc_size_e;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
    case (acc_size_e'(sz))
      ACC_BYTE: size_to_bytes = 3'd1;
      ACC_HALF: size_to_bytes = 3'd2;
      default:  size_to_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH   = 32,
  parameter int PUSH_NB = 4,
  parameter int POP_NB  = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic [$clog2(PUSH_NB+1)-1:0]     push_cnt,
  input  logic [8*PUSH_NB-1:0]             push_word,
  input  logic [$clog2(POP_NB+1)-1:0]      pop_cnt,
  input  logic                             pop_take,
  output logic [8*POP_NB-1:0]              pop_word,
  output logic [$clog2(DEPTH+1)-1:0]       level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] head_q, head_d;
  logic [CW-1:0] level_q, level_d;
  logic [CW-1:0] free_w, push_req, pop_req, push_acc, pop_acc, pop_peek;

  logic [PUSH_NB-1:0] wr_vld;
  logic [AW-1:0]      wr_addr [PUSH_NB];
  logic [7:0]         wr_byte [PUSH_NB];

  // accepted counts, bounded by room and contents
  always_comb begin
    free_w   = CW'(DEPTH) - level_q;
    push_req = CW'(push_cnt);
    pop_req  = CW'(pop_cnt);
    push_acc = (push_req > free_w) ? free_w : push_req;
    pop_peek = (pop_req > level_q) ? level_q : pop_req;
    pop_acc  = pop_take ? pop_peek : '0;
    if (clr) begin
      level_d = '0;
      head_d  = '0;
    end else begin
      level_d = level_q + push_acc - pop_acc;
      head_d  = head_q + AW'(pop_acc);
    end
  end

  // unpack: most significant used lane lands at the tail first
  always_comb begin
    for (int i = 0; i < PUSH_NB; i++) begin
      wr_vld[i]  = !clr && (CW'(i) < push_acc);
      wr_addr[i] = head_q + level_q[AW-1:0] + AW'(i);
      wr_byte[i] = 8'h00;
      if (wr_vld[i]) wr_byte[i] = push_word[8*(int'(push_cnt)-1-i) +: 8];
    end
  end

  // pack: oldest byte in the highest requested lane
  always_comb begin
    pop_word = '0;
    for (int j = 0; j < POP_NB; j++) begin
      if (CW'(j) < pop_peek)
        pop_word[8*(int'(pop_cnt)-1-j) +: 8] = mem[head_q + AW'(j)];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_NB; i++) begin
      if (wr_vld[i]) mem[wr_addr[i]] <= wr_byte[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      head_q  <= '0;
    end else begin
      level_q <= level_d;
      head_q  <= head_d;
    end
  end

  assign level = level_q;

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH));
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             byte_moved,
  output logic             active,
  output logic             dir_wr,
  output logic             rem_nz,
  output logic             data_done,
  output logic             prog_done
);
  logic [LEN_W-1:0] rem_q, rem_d, rem_dec;
  logic act_q, act_d, dir_q, dir_d, dd_q, dd_d, pd_q, pd_d;

  always_comb begin
    rem_dec = rem_q - LEN_W'(byte_moved);
    rem_d   = rem_q;
    act_d   = act_q;
    dir_d   = dir_q;
    dd_d    = dd_q;
    pd_d    = pd_q;
    if (start) begin
      rem_d = len_in;
      act_d = 1'b1;
      dir_d = dir_in;
      dd_d  = 1'b0;
      pd_d  = 1'b0;
    end else if (act_q) begin
      rem_d = rem_dec;
      if (rem_dec == '0) begin
        act_d = 1'b0;
        dd_d  = 1'b1;
        pd_d  = pd_q | dir_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      act_q <= 1'b0;
      dir_q <= 1'b0;
      dd_q  <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      rem_q <= rem_d;
      act_q <= act_d;
      dir_q <= dir_d;
      dd_q  <= dd_d;
      pd_q  <= pd_d;
    end
  end

  assign active    = act_q;
  assign dir_wr    = dir_q;
  assign rem_nz    = (rem_q != '0);
  assign data_done = dd_q;
  assign prog_done = pd_q;

  assert_done_ends_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dd_q) |-> !act_q);
  assert_prog_implies_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> dd_q);
endmodule

// File: rtl/card_fifo_datapath.sv
module card_fifo_datapath
  import card_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W      = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic                            dir_write,
  input  logic [LEN_W-1:0]                xfer_len,
  input  logic                            flush,
  input  logic                            host_wr_en,
  input  logic [1:0]                      host_wr_size,
  input  logic [31:0]                     host_wr_data,
  input  logic                            host_rd_en,
  input  logic [1:0]                      host_rd_size,
  output logic [31:0]                     host_rd_data,
  output logic                            card_tx_valid,
  input  logic                            card_tx_ready,
  output logic [7:0]                      card_tx_data,
  input  logic                            card_rx_valid,
  output logic                            card_rx_ready,
  input  logic [7:0]                      card_rx_data,
  output logic                            xfer_active,
  output logic                            tx_req,
  output logic                            rx_req,
  output logic                            data_done,
  output logic                            prog_done,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] tx_level,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level
);
  localparam int CW = $clog2(FIFO_DEPTH+1);
  localparam int NW = $clog2(HOST_BYTES+1);

  logic dir_wr, rem_nz, tx_fire, rx_fire, rx_req_q, rx_req_d;
  logic [NW-1:0] wr_cnt, rd_cnt;

  assign wr_cnt = (host_wr_en && !start) ? NW'(size_to_bytes(host_wr_size)) : '0;
  assign rd_cnt = NW'(size_to_bytes(host_rd_size));

  assign card_tx_valid = xfer_active && dir_wr && rem_nz && (tx_level != '0);
  assign card_rx_ready = xfer_active && !dir_wr && rem_nz && (rx_level < CW'(FIFO_DEPTH));
  assign tx_fire       = card_tx_valid && card_tx_ready;
  assign rx_fire       = card_rx_valid && card_rx_ready;

  xfer_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_write),
    .len_in(xfer_len), .byte_moved(tx_fire || rx_fire),
    .active(xfer_active), .dir_wr(dir_wr), .rem_nz(rem_nz),
    .data_done(data_done), .prog_done(prog_done)
  );

  byte_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_NB(HOST_BYTES), .POP_NB(1)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(start || flush),
    .push_cnt(wr_cnt), .push_word(host_wr_data),
    .pop_cnt(1'b1), .pop_take(tx_fire),
    .pop_word(card_tx_data), .level(tx_level)
  );

  byte_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_NB(1), .POP_NB(HOST_BYTES)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .push_cnt(rx_fire), .push_word(card_rx_data),
    .pop_cnt(rd_cnt), .pop_take(host_rd_en),
    .pop_word(host_rd_data), .level(rx_level)
  );

  always_comb begin
    rx_req_d = rx_req_q;
    if (start)           rx_req_d = 1'b0;
    else if (rx_fire)    rx_req_d = 1'b1;
    else if (host_rd_en) rx_req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_req_q <= 1'b0;
    else        rx_req_q <= rx_req_d;
  end

  assign rx_req = rx_req_q;
  assign tx_req = xfer_active && dir_wr;

  assert_idle_no_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> (!card_tx_valid && !card_rx_ready));
  assert_rx_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_rx_ready |-> (rx_level < CW'(FIFO_DEPTH)));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_level == '0));
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rx_level == '0 && !data_done && xfer_active && !rx_req));
  assert_rxreq_on_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !start) |=> rx_req);
endmodule

// File: tb/card_fifo_datapath_tb_top.sv
module card_fifo_datapath_tb_top;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic start, dir_write, flush, host_wr_en, host_rd_en;
  logic [15:0] xfer_len;
  logic [1:0] host_wr_size, host_rd_size;
  logic [31:0] host_wr_data, host_rd_data;
  logic card_tx_valid, card_tx_ready, card_rx_valid, card_rx_ready;
  logic [7:0] card_tx_data, card_rx_data;
  logic xfer_active, tx_req, rx_req, data_done, prog_done;
  logic [5:0] tx_level, rx_level;

  always #4 clk = ~clk;

  card_fifo_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
    .xfer_len(xfer_len), .flush(flush), .host_wr_en(host_wr_en),
    .host_wr_size(host_wr_size), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_size(host_rd_size),
    .host_rd_data(host_rd_data), .card_tx_valid(card_tx_valid),
    .card_tx_ready(card_tx_ready), .card_tx_data(card_tx_data),
    .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
    .card_rx_data(card_rx_data), .xfer_active(xfer_active),
    .tx_req(tx_req), .rx_req(rx_req), .data_done(data_done),
    .prog_done(prog_done), .tx_level(tx_level), .rx_level(rx_level)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // stimulus for the next cycle
  bit s_start, s_dir, s_flush, s_wr, s_rd, s_txr, s_rxv;
  int s_len;
  logic [1:0] s_wsz, s_rsz;
  logic [31:0] s_wdata;
  logic [7:0] s_rxd;

  // reference model
  byte unsigned tx_q[$], rx_q[$];
  bit m_act, m_dir, m_dd, m_pd, m_rxreq;
  int m_rem;

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] pack_exp(int n);
    logic [31:0] w = '0;
    int k = (n < rx_q.size()) ? n : rx_q.size();
    for (int j = 0; j < k; j++) w[8*(n-1-j) +: 8] = rx_q[j];
    return w;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic step();
    bit e_tv, e_rr, txf, rxf;
    int n, k, fr;
    start = s_start; dir_write = s_dir; xfer_len = 16'(s_len); flush = s_flush;
    host_wr_en = s_wr; host_wr_size = s_wsz; host_wr_data = s_wdata;
    host_rd_en = s_rd; host_rd_size = s_rsz;
    card_tx_ready = s_txr; card_rx_valid = s_rxv; card_rx_data = s_rxd;
    #1;
    e_tv = m_act && m_dir && m_rem != 0 && tx_q.size() > 0;
    chk(m_act ? "R4" : "R9", 32'(card_tx_valid), 32'(e_tv));
    if (e_tv) chk("R2 R4", 32'(card_tx_data), 32'(tx_q[0]));
    e_rr = m_act && !m_dir && m_rem != 0 && rx_q.size() < DEPTH;
    chk(m_act ? "R5" : "R9", 32'(card_rx_ready), 32'(e_rr));
    if (s_rd && !s_start) chk("R3", host_rd_data, pack_exp(nbytes(s_rsz)));
    txf = e_tv && s_txr;
    rxf = e_rr && s_rxv;
    if (s_start) begin
      tx_q.delete(); rx_q.delete();
      m_act = 1; m_dir = s_dir; m_rem = s_len; m_dd = 0; m_pd = 0; m_rxreq = 0;
    end else begin
      fr = DEPTH - tx_q.size();
      if (s_flush) tx_q.delete();
      else begin
        if (txf) void'(tx_q.pop_front());
        if (s_wr) begin
          n = nbytes(s_wsz);
          k = (n < fr) ? n : fr;
          for (int i = 0; i < k; i++) tx_q.push_back(s_wdata[8*(n-1-i) +: 8]);
        end
      end
      if (s_rd) begin
        n = nbytes(s_rsz);
        k = (n < rx_q.size()) ? n : rx_q.size();
        for (int i = 0; i < k; i++) void'(rx_q.pop_front());
      end
      if (rxf) rx_q.push_back(s_rxd);
      if (rxf) m_rxreq = 1; else if (s_rd) m_rxreq = 0;
      if (m_act) begin
        if (txf || rxf) m_rem--;
        if (m_rem == 0) begin m_act = 0; m_dd = 1; if (m_dir) m_pd = 1; end
      end
    end
    @(negedge clk);
    chk("R6", 32'(xfer_active), 32'(m_act));
    chk("R6", 32'(data_done), 32'(m_dd));
    chk("R6", 32'(prog_done), 32'(m_pd));
    chk(s_flush ? "R8" : (s_start ? "R9" : "R1"), 32'(tx_level), 32'(tx_q.size()));
    chk(s_start ? "R9" : "R1", 32'(rx_level), 32'(rx_q.size()));
    chk("R7", 32'(rx_req), 32'(m_rxreq));
    chk("R7", 32'(tx_req), 32'(m_act && m_dir));
    s_start = 0; s_flush = 0;
  endtask

  task automatic quiet();
    s_wr = 0; s_rd = 0; s_txr = 0; s_rxv = 0; s_flush = 0; s_start = 0;
  endtask

  task automatic begin_xfer(bit d, int len);
    quiet(); s_start = 1; s_dir = d; s_len = len; step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    quiet(); s_dir = 0; s_len = 0; s_wsz = 0; s_rsz = 0; s_wdata = 0; s_rxd = 0;
    rst_n = 0;
    start = 0; dir_write = 0; xfer_len = 0; flush = 0; host_wr_en = 0;
    host_wr_size = 0; host_wr_data = 0; host_rd_en = 0; host_rd_size = 0;
    card_tx_ready = 0; card_rx_valid = 0; card_rx_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", 32'(xfer_active), 0);
    chk("R10", 32'(tx_level), 0);
    chk("R10", 32'(rx_level), 0);
    chk("R10", {29'd0, data_done, prog_done, rx_req}, 0);

    // R2 R4 R6: write transfer of 6 bytes, word then half
    begin_xfer(1, 6);
    s_wr = 1; s_wsz = 2'd2; s_wdata = 32'hA1B2C3D4; step();
    s_wsz = 2'd1; s_wdata = 32'h1234E5F6; step();
    s_wr = 0; s_txr = 1; repeat (8) step();

    // R8 flush with pending bytes and a same-cycle write
    begin_xfer(1, 20);
    s_wr = 1; s_wsz = 2'd2; s_wdata = 32'h01020304; step();
    s_flush = 1; s_wdata = 32'h05060708; step();
    s_wr = 0; repeat (2) step();

    // R3 R5 read transfer of 5 bytes, then word and half reads
    begin_xfer(0, 5);
    for (int i = 0; i < 7; i++) begin s_rxv = 1; s_rxd = 8'(8'h11 + i); step(); end
    s_rxv = 0; s_rd = 1; s_rsz = 2'd2; step();
    s_rsz = 2'd1; step();
    s_rsz = 2'd0; step();
    s_rd = 0;

    // R1 R5 receive queue fills to 32 and stops accepting
    begin_xfer(0, 40);
    for (int i = 0; i < 36; i++) begin s_rxv = 1; s_rxd = 8'($urandom); step(); end
    s_rxv = 0; s_rd = 1; s_rsz = 2'd3; repeat (9) step(); s_rd = 0;

    // R1 transmit overflow drops excess bytes
    begin_xfer(1, 100);
    for (int i = 0; i < 9; i++) begin
      s_wr = 1; s_wsz = 2'd2; s_wdata = $urandom; step();
    end
    s_wr = 0; s_txr = 1; repeat (4) step();

    // R6 zero-length transfer
    begin_xfer(1, 0); repeat (2) step();
    begin_xfer(0, 0); repeat (2) step();

    // random phases
    for (int p = 0; p < 50; p++) begin
      begin_xfer(1'($urandom % 2), int'($urandom % 50));
      for (int c = 0; c < 30; c++) begin
        s_wr = ($urandom % 3) == 0; s_wsz = 2'($urandom); s_wdata = $urandom;
        s_rd = ($urandom % 3) == 0; s_rsz = 2'($urandom);
        s_flush = ($urandom % 17) == 0;
        s_txr = 1'($urandom); s_rxv = 1'($urandom); s_rxd = 8'($urandom);
        step();
      end
    end
    finish_run();
  end
endmodule